// File: doc/BRIEF.md
# Capture/Compare Timer Counter

This block is an up-counter with two capture/compare registers. Software selects one of three counting modes, or leaves the block stopped. It can run free, restart from zero after a qualified edge on trigger input 0, or restart from zero after reaching the value in register 0. Each register works either as a compare register or as a capture register. A compare register raises its interrupt while the counter equals its value. A capture register takes a snapshot of the counter when its trigger input fires. Register 0 is triggered by input 1, and register 1 by input 0.

Timing comes from a prescaled count-clock level, `cclk`, which is sampled on the system clock. A rising edge of `cclk` advances the counter. A falling edge is the moment at which a pending capture is latched. The interrupt for that capture follows on the next rising edge. The trigger inputs are one-cycle events that an edge detector outside the block has already qualified. A one-shot output can be armed by software. It rises when the counter reaches register 1 and falls when the counter reaches register 0. The one-shot is refused while the counter restarts on a register-0 match, because the counter never wraps in that mode.

Top module: `capcmp_timer`

## Requirements
- R1: Mode field `ctrl[1:0]` encodes 0 = stopped, 1 = free-running, 2 = clear on trigger 0, 3 = clear on register-0 match. When stopped, the counter is held at 0. In the other modes it advances by one on every rising edge of `cclk`.
- R2: In mode 3, the counter holds the value of register 0 for one count period. The next count tick reloads it to 0, and the overflow flag is never set.
- R3: A count tick that moves the counter from all-ones to 0 sets `ovf_flag`. Writing address 3 with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it set.
- R4: A register in compare mode (`ctrl[2]` for register 0, `ctrl[3]` for register 1, 0 = compare) drives its interrupt high for exactly the count period in which the counter equals it.
- R5: A register in capture mode latches the counter on the first falling edge of `cclk` after its trigger event. Its interrupt rises on the following rising edge and stays high for one count period.
- R6: A captured value is held until a later trigger is latched, or until software writes the register (address 1 = register 0, address 2 = register 1).
- R7: A register in compare mode never captures, whatever its trigger input does.
- R8: While stopped, trigger events on both inputs are discarded. They are not latched and they do not remain pending once the timer is started.
- R9: With `ctrl[4]` = 1, trigger-0 events replace `cclk` rising edges as the count tick. Trigger 0 then neither captures into register 1 nor clears the counter.
- R10: Reading the counter (read address 3) has no side effect on register 1.
- R11: In mode 2, a trigger-0 event makes the next count tick load 0 instead of incrementing.
- R12: Writing address 0 with bit 5 = 1 and a mode of 1 or 2 arms the one-shot. `tmr_out` rises at the tick on which the counter becomes equal to register 1 and falls at the tick on which it becomes equal to register 0. It then stays low until the one-shot is armed again. The arm request is ignored in modes 0 and 3, and `tmr_out` is low in those modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cclk | input | 1 | Prescaled count-clock level, synchronous to clk |
| trig0_evt | input | 1 | Qualified event on trigger input 0 (one cycle) |
| trig1_evt | input | 1 | Qualified event on trigger input 1 (one cycle) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 register 0, 2 register 1, 3 status clear |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 register 0, 2 register 1, 3 counter |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq0 | output | 1 | Register 0 interrupt |
| irq1 | output | 1 | Register 1 interrupt |
| tmr_out | output | 1 | One-shot pulse output |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A counter that steps or reloads wrongly shows up in the counter value read at address 3 within one count period. It also shows up later as a misplaced `irq0`, `irq1` or `tmr_out` edge, because these are all compared against the next counter value. A capture pending flag that is stuck, or that was not cleared, shows up at the first falling edge of `cclk`: the wrong value appears in register 1 or register 0 immediately, and the interrupt follows one rising edge later. Sticky state such as `ovf_flag` and the one-shot arm flag shows up only at the next wrap or match, so the corner tests drive the counter through a full wrap.

// File: rtl/cct_pkg.sv
// Package: shared encodings for the capture/compare timer.
// Assumes a 2-bit register address space and a control word of at least 6 bits.
package cct_pkg;
    typedef enum logic [1:0] {
        MODE_STOP     = 2'd0,
        MODE_FREE     = 2'd1,
        MODE_TRIGCLR  = 2'd2,
        MODE_MATCHCLR = 2'd3
    } cct_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CR0  = 2'd1;
    localparam logic [1:0] ADDR_CR1  = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    localparam int BIT_CAP0  = 2;
    localparam int BIT_CAP1  = 3;
    localparam int BIT_EXT   = 4;
    localparam int BIT_SHOT  = 5;
    localparam int CTRL_BITS = 5;
endpackage

// File: rtl/cct_tick_gen.sv
// Tick generator: derives the count tick and the capture strobe from the
// count-clock level. Assumes cclk is already synchronous to clk.
module cct_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cclk,
    input  logic trig0_evt,
    input  logic ext_clk,
    output logic tick,
    output logic fall
);
    logic cclk_q;

    // Remember the previous count-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cclk_q <= 1'b0;
        else        cclk_q <= cclk;
    end

    assign tick = ext_clk ? trig0_evt : (cclk & ~cclk_q);
    assign fall = ~cclk & cclk_q;
endmodule

// File: rtl/cct_counter.sv
// Counter core: holds, increments or reloads the counter on each tick according
// to the mode, and keeps the sticky overflow flag. Assumes clr_evt is already
// masked when trigger 0 serves as the count clock.
module cct_counter
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cct_mode_e    mode,
    input  logic         tick,
    input  logic         clr_evt,
    input  logic [W-1:0] cmp0,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic run;
    logic clr_pend;
    logic reload;

    assign run = (mode != MODE_STOP);

    // Decide the value the counter takes on the next tick.
    always_comb begin
        reload   = ((mode == MODE_MATCHCLR) && (cnt == cmp0)) ||
                   ((mode == MODE_TRIGCLR) && clr_pend);
        cnt_next = reload ? '0 : cnt + 1'b1;
    end

    // Hold a trigger-0 clear request until the next tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) clr_pend <= 1'b0;
        else                clr_pend <= (clr_pend & ~tick) |
                                        (clr_evt & (mode == MODE_TRIGCLR));
    end

    // Counter register: zero when stopped, step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= cnt_next;
    end

    // Sticky overflow flag; setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ovf <= 1'b0;
        else if (run && tick && !reload && cnt == CNT_MAX) ovf <= 1'b1;
        else if (ovf_clr)                             ovf <= 1'b0;
    end
endmodule

// File: rtl/cct_channel.sv
// Capture/compare channel: one register that either compares against the
// counter or latches it on a trigger at the count-clock falling edge.
// Assumes fall and tick never occur in the same cycle when driven by cclk.
module cct_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cap_mode,
    input  logic         cap_trig,
    input  logic         fall,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_next,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cr,
    output logic         irq
);
    logic pend;
    logic done;
    logic latch;

    assign latch = run & cap_mode & pend & fall;

    // Keep a trigger pending until the next falling edge of the count clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !cap_mode) pend <= 1'b0;
        else                             pend <= (pend & ~fall) | cap_trig;
    end

    // Register value: software write, else capture snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)     cr <= '0;
        else if (wr)    cr <= wr_data;
        else if (latch) cr <= cnt;
    end

    // Remember a completed capture until the next tick reports it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) done <= 1'b0;
        else if (latch)     done <= 1'b1;
        else if (tick)      done <= 1'b0;
    end

    // Interrupt level, updated once per count period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) irq <= 1'b0;
        else if (tick)      irq <= (!cap_mode && cnt_next == cr) || done;
    end
endmodule

// File: rtl/cct_oneshot.sv
// One-shot output: once armed, rises when the counter reaches cmp1 and falls
// when it reaches cmp0. Assumes arm_req is only raised for an allowed mode.
module cct_oneshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         allow,
    input  logic         arm_req,
    input  logic         tick,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    output logic         pulse
);
    logic armed;

    // Arm, fire and end the pulse on count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            pulse <= 1'b0;
        end else if (arm_req) begin
            armed <= 1'b1;
            pulse <= 1'b0;
        end else if (!allow) begin
            armed <= 1'b0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (armed && !pulse && cnt_next == cmp1) begin
                pulse <= 1'b1;
            end else if (pulse && cnt_next == cmp0) begin
                pulse <= 1'b0;
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/capcmp_timer.sv
// Capture/compare timer top: control register, register access, counter core,
// two channels and the one-shot output. Assumes CNT_W > CTRL_BITS.
module capcmp_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cclk,
    input  logic             trig0_evt,
    input  logic             trig1_evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq0,
    output logic             irq1,
    output logic             tmr_out,
    output logic             ovf_flag
);
    localparam int NCH  = 2;
    localparam int PADW = CNT_W - CTRL_BITS;

    cct_mode_e        ctrl_mode;
    logic             cap0_sel, cap1_sel, ext_sel;
    logic             tick, fall, run, arm_req, ovf_clr;
    logic [CNT_W-1:0] cnt_val, cnt_next;
    logic [CNT_W-1:0] cr_val [NCH];
    logic             irq_v  [NCH];
    logic             cap_sel[NCH];
    logic             cap_trg[NCH];

    assign run        = (ctrl_mode != MODE_STOP);
    assign cap_sel[0] = cap0_sel;
    assign cap_sel[1] = cap1_sel;
    assign cap_trg[0] = trig1_evt;
    assign cap_trg[1] = trig0_evt & ~ext_sel;
    assign ovf_clr    = wr_en && wr_addr == ADDR_CNT && wr_data[0];
    assign arm_req    = wr_en && wr_addr == ADDR_CTRL && wr_data[BIT_SHOT] &&
                        (wr_data[1:0] == MODE_FREE || wr_data[1:0] == MODE_TRIGCLR);

    // Control register: mode, capture selects and count-clock source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_mode <= MODE_STOP;
            cap0_sel  <= 1'b0;
            cap1_sel  <= 1'b0;
            ext_sel   <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl_mode <= cct_mode_e'(wr_data[1:0]);
            cap0_sel  <= wr_data[BIT_CAP0];
            cap1_sel  <= wr_data[BIT_CAP1];
            ext_sel   <= wr_data[BIT_EXT];
        end
    end

    // Read multiplexer; reads have no side effects.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = {{PADW{1'b0}}, ext_sel, cap1_sel, cap0_sel, ctrl_mode};
            ADDR_CR0:  rd_data = cr_val[0];
            ADDR_CR1:  rd_data = cr_val[1];
            default:   rd_data = cnt_val;
        endcase
    end

    cct_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .cclk(cclk), .trig0_evt(trig0_evt),
        .ext_clk(ext_sel), .tick(tick), .fall(fall)
    );

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_mode), .tick(tick),
        .clr_evt(trig0_evt & ~ext_sel), .cmp0(cr_val[0]), .ovf_clr(ovf_clr),
        .cnt(cnt_val), .cnt_next(cnt_next), .ovf(ovf_flag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cct_channel #(.W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .cap_mode(cap_sel[i]),
            .cap_trig(cap_trg[i]), .fall(fall), .tick(tick), .cnt(cnt_val),
            .cnt_next(cnt_next), .wr(wr_en && wr_addr == 2'(i + 1)),
            .wr_data(wr_data), .cr(cr_val[i]), .irq(irq_v[i])
        );
    end

    assign irq0 = irq_v[0];
    assign irq1 = irq_v[1];

    cct_oneshot #(.W(CNT_W)) u_shot (
        .clk(clk), .rst_n(rst_n),
        .allow(ctrl_mode == MODE_FREE || ctrl_mode == MODE_TRIGCLR),
        .arm_req(arm_req), .tick(tick), .cnt_next(cnt_next),
        .cmp0(cr_val[0]), .cmp1(cr_val[1]), .pulse(tmr_out)
    );
endmodule

// File: rtl/cct_checker.sv
// Checker: temporal properties of the capture/compare timer, bound to the top.
// Assumes the mode is passed as its raw 2-bit encoding.
module cct_checker
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic         tick,
    input logic         ext,
    input logic         cap0,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cr0,
    input logic [W-1:0] cr1,
    input logic         ovf,
    input logic         pulse,
    input logic         wr_en,
    input logic [1:0]   wr_addr
);
    logic wr_cr0, wr_cr1;
    assign wr_cr0 = wr_en && wr_addr == ADDR_CR0;
    assign wr_cr1 = wr_en && wr_addr == ADDR_CR1;

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_STOP |=> cnt == '0); // R1
    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MATCHCLR && tick && cnt == cr0) |=> cnt == '0); // R2
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(cnt) == {W{1'b1}}); // R3
    AST_NO_CAP_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap0 && !wr_cr0) |=> $stable(cr0)); // R7
    AST_STOP_HOLDS_CR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !wr_cr1) |=> $stable(cr1)); // R8
    AST_EXT_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && !wr_cr1) |=> $stable(cr1)); // R9
    AST_NO_PULSE_MATCHCLR: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_MATCHCLR |=> !pulse); // R12
endmodule

bind capcmp_timer cct_checker #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_mode), .tick(tick), .ext(ext_sel),
    .cap0(cap0_sel), .cnt(cnt_val), .cr0(cr_val[0]), .cr1(cr_val[1]),
    .ovf(ovf_flag), .pulse(tmr_out), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  cr0;
        logic [15:0] ticks;
        logic [7:0]  exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h01, 8'd0,   16'd5,   8'd5,  1'b0},  // R1 free-running
        '{8'h03, 8'd3,   16'd6,   8'd2,  1'b0},  // R2 match reload
        '{8'h00, 8'd0,   16'd5,   8'd0,  1'b0},  // R1 stopped
        '{8'h01, 8'd0,   16'd256, 8'd0,  1'b1},  // R3 wrap
        '{8'h03, 8'd255, 16'd256, 8'd0,  1'b0},  // R2 no overflow
        '{8'h01, 8'd0,   16'd300, 8'd44, 1'b1}   // R3 past wrap
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cclk = 1'b0;
    logic         trig0_evt = 1'b0;
    logic         trig1_evt = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq0, irq1, tmr_out, ovf_flag;

    int n_tests = 0;
    int n_fail  = 0;

    capcmp_timer #(.CNT_W(W)) u_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .cclk(cclk), .trig0_evt(trig0_evt),
        .trig1_evt(trig1_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq0(irq0), .irq1(irq1), .tmr_out(tmr_out), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic rise();
        cclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic fall();
        cclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            rise();
            fall();
        end
    endtask

    task automatic pulse0();
        trig0_evt = 1'b1;
        @(negedge clk);
        trig0_evt = 1'b0;
    endtask

    task automatic pulse1();
        trig1_evt = 1'b1;
        @(negedge clk);
        trig1_evt = 1'b0;
    endtask

    task automatic restart(input int c0, input int c1, input int ctrl);
        wr(2'd0, 0);
        wr(2'd3, 1);
        wr(2'd1, c0);
        wr(2'd2, c1);
        wr(2'd0, ctrl);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(2'd3, v); check("R1 reset counter", v, 0);
        rd(2'd0, v); check("R1 reset control", v, 0);
        rd(2'd1, v); check("R6 reset register 0", v, 0);
        check("R3 reset overflow", ovf_flag, 0);
        check("R4 reset irq0", irq0, 0);
        check("R12 reset output", tmr_out, 0);

        // Vector table: mode, count and overflow
        for (int k = 0; k < NVEC; k++) begin
            restart(int'(VECS[k].cr0), 0, int'(VECS[k].ctrl));
            ticks(int'(VECS[k].ticks));
            rd(2'd3, v); check("R1/R2 vector counter", v, int'(VECS[k].exp_cnt));
            check("R3 vector overflow", ovf_flag, int'(VECS[k].exp_ovf));
        end

        // R3: writing 0 keeps the flag, writing 1 clears it
        wr(2'd3, 0); check("R3 write zero keeps flag", ovf_flag, 1);
        wr(2'd3, 1); check("R3 write one clears flag", ovf_flag, 0);

        // R4: compare interrupt for one count period
        restart(200, 3, 8'h01);
        ticks(2);       check("R4 before match", irq1, 0);
        ticks(1);       check("R4 at match", irq1, 1);
        ticks(1);       check("R4 after match", irq1, 0);

        // R5: capture on falling edge, interrupt on next rising edge
        restart(200, 0, 8'h09);
        ticks(4);
        pulse0();
        rd(2'd2, v); check("R5 no latch before fall", v, 0);
        rise();
        rd(2'd2, v); check("R5 no latch on rise", v, 0);
        fall();
        rd(2'd2, v); check("R5 latched on fall", v, 5);
        check("R5 irq waits for rise", irq1, 0);
        rise();
        check("R5 irq on next rise", irq1, 1);
        fall(); rise();
        check("R5 irq lasts one period", irq1, 0);
        fall();
        // R6 hold, R10 read has no side effect
        ticks(3);
        rd(2'd2, v); check("R6 capture held", v, 5);
        rd(2'd3, v); rd(2'd3, v);
        rd(2'd2, v); check("R10 counter read no capture", v, 5);

        // R7: compare mode ignores capture triggers
        restart(88, 77, 8'h01);
        pulse0(); pulse1();
        ticks(1);
        rd(2'd2, v); check("R7 register 1 not captured", v, 77);
        rd(2'd1, v); check("R7 register 0 not captured", v, 88);

        // R8: stopped timer discards triggers
        restart(200, 9, 8'h08);
        pulse0();
        ticks(1);
        rd(2'd2, v); check("R8 no capture while stopped", v, 9);
        wr(2'd0, 8'h09);
        ticks(1);
        rd(2'd2, v); check("R8 no stale pending", v, 9);
        rd(2'd3, v); check("R8 counter after start", v, 1);

        // R9: trigger 0 as count clock
        restart(200, 170, 8'h19);
        for (int i = 0; i < 3; i++) begin
            pulse0();
            rise();
            fall();
        end
        rd(2'd3, v); check("R9 counts trigger events", v, 3);
        rd(2'd2, v); check("R9 no capture from count clock", v, 170);

        // R11: clear on trigger 0
        restart(200, 0, 8'h02);
        ticks(5);
        pulse0();
        rd(2'd3, v); check("R11 clear waits for tick", v, 5);
        rise();
        rd(2'd3, v); check("R11 cleared on tick", v, 0);
        fall(); ticks(1);
        rd(2'd3, v); check("R11 counts after clear", v, 1);

        // R12: one-shot in free-running mode
        restart(10, 6, 8'h21);
        ticks(5);  check("R12 low before start match", tmr_out, 0);
        ticks(1);  check("R12 high at register 1", tmr_out, 1);
        ticks(3);  check("R12 still high", tmr_out, 1);
        ticks(1);  check("R12 low at register 0", tmr_out, 0);
        ticks(6);  check("R12 not re-armed", tmr_out, 0);

        // R12: refused in match-clear mode
        restart(10, 6, 8'h23);
        ticks(6);  check("R12 refused in match mode", tmr_out, 0);
        ticks(2);  check("R12 stays low in match mode", tmr_out, 0);

        summary();
        $finish;
    end
endmodule